// File: doc/BRIEF.md
# MDIO Management Register Controller

This block gives a host processor access to the registers of external PHY devices over the two-wire management bus. The bus has a clock pin (MDC) and a bidirectional data pin (MDIO). The host sees six word registers behind a small select-and-strobe interface:

- a configuration word holding the clock divider code and the preamble option;
- a command word whose read bit starts a read frame;
- an address word holding the PHY number and the register number;
- a write-data word that starts a write frame as soon as it is written;
- a read-data word holding the last value returned by a PHY;
- a status word with busy and not-valid flags.

The block builds standard clause-22 frames. Each frame begins with an optional preamble of 32 ones. The rest of the frame, in order, is:

- the start pair 01;
- the opcode, 10 for a read or 01 for a write;
- five bits of PHY number;
- five bits of register number;
- a two-bit turnaround;
- sixteen data bits, most significant bit first.

MDC runs only while a frame is in progress, and its period is the system clock divided by an even divisor picked from an eight-entry table. On a read, the controller releases MDIO for the turnaround and data bits and samples the pin on each MDC rising edge.

To read, software sets the PHY and register numbers, writes the command word with the read bit cleared, then writes it with the read bit set. It then polls the status word until both flags are low, and takes the data. To write, software sets the address and writes the data word.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, every host-visible register reads 0, MDC is low and MDIO is not driven (mdio_oe low).
- R2: Register select codes are 0 config, 1 command, 2 address, 3 write data, 4 read data and 5 status. Read data for a select appears on host_rdata one cycle after the select is applied. The fields are:
  - config: bit 5 is the stored scan-step bit, bit 4 is the preamble suppress bit and bits 2:0 are the divider code;
  - command: bit 1 is a stored scan request and bit 0 is the read request;
  - address: bits 12:8 are the PHY number and bits 4:0 are the register number.
  All other bits read 0.
- R3: A host write to select 3 while idle starts a write frame carrying the low 16 bits of the written word. The frame is the preamble (unless suppressed), then 01, 01, PHY, register, 10 and the data, with MDIO driven for every bit. A read of select 3 returns the accepted value.
- R4: Setting command bit 0 from 0 to 1 while idle starts a read frame: the preamble (unless suppressed), then 01, 10, PHY and register. MDIO is released for the last 18 bits. The 16 bits sampled on the MDC rising edges of the data phase, first bit as most significant, appear in the read-data register.
- R5: Writing command bit 0 as 1 when it already holds 1 starts no frame.
- R6: With config bit 4 set, a frame is 32 MDC periods long and has no preamble. Otherwise it is 64 periods long.
- R7: Divider codes 0 to 7 give MDC periods of 4, 4, 6, 8, 10, 14, 20 and 28 system clocks, each with equal high and low halves. Status bit 0 (busy) stays high for exactly frame bits times period cycles.
- R8: Status bit 2 (not-valid) rises with busy on a read launch and clears on the rising MDC edge of the last data bit, half a period before busy. It never rises on a write frame.
- R9: While busy, host writes to select 3 and read requests are ignored: the running frame, the stored write data and the flags are unaffected.
- R10: Writing config with bit 31 set aborts any frame on the following edge: busy and not-valid clear, MDC goes low and MDIO is released. Bit 31 always reads back as 0.
- R11: MDC is low whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 3 | Register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data for host_sel |
| mdc | output | 1 | Management bus clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high drives the pin) |
| mdio_i | input | 1 | MDIO pin input value |

## Verification
A launch takes effect on the clock edge that accepts the host write. Busy reaches host_rdata one edge later. It then stays visible for exactly bits times divisor samples, and not-valid for half an MDC period fewer. The bench counts these samples at falling system-clock edges and compares the counts with values derived from the divider table.

The first MDC rise falls half a period after the launch. A bench model samples MDIO on every MDC rising edge and drives the read response after each MDC falling edge, so every returned bit is stable at least two system clocks before it is captured. An abort is checked on the first falling edge after the accepting edge. Read-data and status values are checked only once the busy flag has been seen low.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  typedef enum logic [2:0] {
    RS_CFG  = 3'd0,
    RS_CMD  = 3'd1,
    RS_ADDR = 3'd2,
    RS_CTRL = 3'd3,
    RS_STAT = 3'd4,
    RS_IND  = 3'd5
  } reg_sel_e;

  // Half of the MDC period, in system clocks, for each divider code.
  function automatic logic [3:0] mdc_half(input logic [2:0] code);
    case (code)
      3'd0, 3'd1: mdc_half = 4'd2;
      3'd2:       mdc_half = 4'd3;
      3'd3:       mdc_half = 4'd4;
      3'd4:       mdc_half = 4'd5;
      3'd5:       mdc_half = 4'd7;
      3'd6:       mdc_half = 4'd10;
      default:    mdc_half = 4'd14;
    endcase
  endfunction

endpackage

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       run,
  input  logic [2:0] div_code,
  output logic       mdc,
  output logic       rise_evt,
  output logic       fall_evt
);
  import mdio_mgmt_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             tick;

  assign half_m1  = CNT_W'(mdc_half(div_code)) - CNT_W'(1);
  assign tick     = run && (cnt == half_m1);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || abort || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine #(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              launch_wr,
  input  logic              launch_rd,
  input  logic              no_pre,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic              nv,
  output logic [DATA_W-1:0] status,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int HDR_W   = 6 + PHY_W + REG_W;
  localparam int BODY_W  = HDR_W + DATA_W;
  localparam int FRAME_W = PRE_LEN + BODY_W;
  localparam int DRV_RD  = HDR_W - 2;
  localparam int IDX_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_q, oemask_q;
  logic [IDX_W-1:0]   idx_q, last_q, dstart_q;
  logic               is_rd_q;
  logic [DATA_W-1:0]  rx_q;

  logic [BODY_W-1:0]  body, body_oe;
  logic [FRAME_W-1:0] frame_ld, oemask_ld;

  always_comb begin
    if (launch_rd) begin
      body    = {2'b01, 2'b10, phy, regn, 2'b11, {DATA_W{1'b1}}};
      body_oe = {{DRV_RD{1'b1}}, {(BODY_W-DRV_RD){1'b0}}};
    end else begin
      body    = {2'b01, 2'b01, phy, regn, 2'b10, wdata};
      body_oe = {BODY_W{1'b1}};
    end
    if (no_pre) begin
      frame_ld  = {body, {PRE_LEN{1'b0}}};
      oemask_ld = {body_oe, {PRE_LEN{1'b0}}};
    end else begin
      frame_ld  = {{PRE_LEN{1'b1}}, body};
      oemask_ld = {{PRE_LEN{1'b1}}, body_oe};
    end
  end

  assign mdio_o  = frame_q[FRAME_W-1];
  assign mdio_oe = oemask_q[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      nv       <= 1'b0;
      is_rd_q  <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      dstart_q <= '0;
      frame_q  <= '0;
      oemask_q <= '0;
      rx_q     <= '0;
      status   <= '0;
    end else if (abort) begin
      busy     <= 1'b0;
      nv       <= 1'b0;
      idx_q    <= '0;
      frame_q  <= '0;
      oemask_q <= '0;
    end else if (!busy) begin
      if (launch_wr || launch_rd) begin
        busy     <= 1'b1;
        nv       <= launch_rd;
        is_rd_q  <= launch_rd;
        idx_q    <= '0;
        last_q   <= no_pre ? IDX_W'(BODY_W - 1) : IDX_W'(FRAME_W - 1);
        dstart_q <= no_pre ? IDX_W'(HDR_W) : IDX_W'(PRE_LEN + HDR_W);
        frame_q  <= frame_ld;
        oemask_q <= oemask_ld;
      end
    end else begin
      if (rise_evt && is_rd_q && (idx_q >= dstart_q)) begin
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
        if (idx_q == last_q) begin
          status <= {rx_q[DATA_W-2:0], mdio_i};
          nv     <= 1'b0;
        end
      end
      if (fall_evt) begin
        if (idx_q == last_q) begin
          busy     <= 1'b0;
          frame_q  <= '0;
          oemask_q <= '0;
        end else begin
          idx_q    <= idx_q + IDX_W'(1);
          frame_q  <= {frame_q[FRAME_W-2:0], 1'b0};
          oemask_q <= {oemask_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs #(
  parameter int DATA_W = 16,
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              nv,
  input  logic [DATA_W-1:0] status,
  output logic              launch_wr,
  output logic              launch_rd,
  output logic              abort,
  output logic              no_pre,
  output logic [2:0]        div_code,
  output logic [PHY_W-1:0]  phy,
  output logic [REG_W-1:0]  regn,
  output logic [DATA_W-1:0] ctrl_q
);
  import mdio_mgmt_pkg::*;

  localparam int PHY_LSB = 8;

  logic scan_step_q, scan_req_q, rd_req_q;
  logic wr_cfg, wr_cmd, wr_addr, wr_ctrl;

  assign wr_cfg  = host_we && (host_sel == RS_CFG);
  assign wr_cmd  = host_we && (host_sel == RS_CMD);
  assign wr_addr = host_we && (host_sel == RS_ADDR);
  assign wr_ctrl = host_we && (host_sel == RS_CTRL);

  assign launch_wr = wr_ctrl && !busy;
  assign launch_rd = wr_cmd && host_wdata[0] && !rd_req_q && !busy;
  assign abort     = wr_cfg && host_wdata[HOST_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      no_pre      <= 1'b0;
      scan_step_q <= 1'b0;
      div_code    <= '0;
      rd_req_q    <= 1'b0;
      scan_req_q  <= 1'b0;
      phy         <= '0;
      regn        <= '0;
      ctrl_q      <= '0;
      host_rdata  <= '0;
    end else begin
      if (wr_cfg) begin
        no_pre      <= host_wdata[4];
        scan_step_q <= host_wdata[5];
        div_code    <= host_wdata[2:0];
      end
      if (wr_cmd) begin
        rd_req_q   <= host_wdata[0];
        scan_req_q <= host_wdata[1];
      end
      if (wr_addr) begin
        phy  <= host_wdata[PHY_LSB +: PHY_W];
        regn <= host_wdata[0 +: REG_W];
      end
      if (launch_wr) ctrl_q <= host_wdata[DATA_W-1:0];

      case (reg_sel_e'(host_sel))
        RS_CFG:  host_rdata <= HOST_W'({scan_step_q, no_pre, 1'b0, div_code});
        RS_CMD:  host_rdata <= HOST_W'({scan_req_q, rd_req_q});
        RS_ADDR: host_rdata <= (HOST_W'(phy) << PHY_LSB) | HOST_W'(regn);
        RS_CTRL: host_rdata <= HOST_W'(ctrl_q);
        RS_STAT: host_rdata <= HOST_W'(status);
        RS_IND:  host_rdata <= HOST_W'({nv, 1'b0, busy});
        default: host_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int HOST_W  = 32,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic              busy_w, nv_w, launch_wr, launch_rd, abort_w, no_pre;
  logic              rise_evt, fall_evt;
  logic [2:0]        div_code;
  logic [PHY_W-1:0]  phy;
  logic [REG_W-1:0]  regn;
  logic [DATA_W-1:0] ctrl_q, status;

  mdio_mgmt_regs #(
    .DATA_W(DATA_W), .PHY_W(PHY_W), .REG_W(REG_W), .HOST_W(HOST_W)
  ) u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy_w), .nv(nv_w), .status(status),
    .launch_wr(launch_wr), .launch_rd(launch_rd), .abort(abort_w),
    .no_pre(no_pre), .div_code(div_code), .phy(phy), .regn(regn),
    .ctrl_q(ctrl_q)
  );

  mdio_mgmt_clkgen #(.CNT_W(CNT_W)) u_clk (
    .clk(clk), .rst(rst), .abort(abort_w), .run(busy_w),
    .div_code(div_code), .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_mgmt_engine #(
    .PRE_LEN(PRE_LEN), .DATA_W(DATA_W), .PHY_W(PHY_W), .REG_W(REG_W)
  ) u_eng (
    .clk(clk), .rst(rst), .abort(abort_w),
    .launch_wr(launch_wr), .launch_rd(launch_rd), .no_pre(no_pre),
    .phy(phy), .regn(regn), .wdata(host_wdata[DATA_W-1:0]),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .busy(busy_w), .nv(nv_w), .status(status),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int DATA_W = 16,
  parameter int HOST_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              host_we,
  input logic [2:0]        host_sel,
  input logic [HOST_W-1:0] host_wdata,
  input logic              busy,
  input logic              nv,
  input logic              mdc,
  input logic              mdio_oe,
  input logic [DATA_W-1:0] ctrl_q
);
  // R1: reset leaves the bus idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !mdc && !mdio_oe));

  // R11: no MDC activity without a frame
  a_r11_mdc_low_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R3: MDIO never driven outside a frame
  a_r3_oe_only_busy: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  // R8: not-valid only inside a frame
  a_r8_nv_within_busy: assert property (@(posedge clk) disable iff (rst)
    nv |-> busy);

  // R9: write data held while busy
  a_r9_ctrl_held: assert property (@(posedge clk) disable iff (rst)
    (busy && host_we && host_sel == 3'd3) |=> $stable(ctrl_q));

  // R10: abort clears the flags on the next edge
  a_r10_abort: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_sel == 3'd0 && host_wdata[HOST_W-1]) |=> (!busy && !nv && !mdc));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.DATA_W(DATA_W), .HOST_W(HOST_W)) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
  .host_wdata(host_wdata), .busy(busy_w), .nv(nv_w), .mdc(mdc),
  .mdio_oe(mdio_oe), .ctrl_q(ctrl_q)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [2:0]  host_sel = 3'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  mdio_mgmt_ctrl u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: logs bits on MDC rise, answers reads after MDC fall
  int          frame_tag = 0;
  int          seen_tag = 0;
  int          rise_cnt = 0;
  logic        mdc_prev = 1'b0;
  logic [63:0] log_o = '0, log_oe = '0;
  int          rsp_start = 1000;
  logic [15:0] rsp_data = '0;

  always @(negedge clk) begin
    if (frame_tag != seen_tag) begin
      seen_tag <= frame_tag;
      rise_cnt <= 0;
      log_o    <= '0;
      log_oe   <= '0;
      mdio_i   <= 1'b1;
    end else begin
      if (mdc && !mdc_prev) begin
        log_o    <= {log_o[62:0], mdio_o};
        log_oe   <= {log_oe[62:0], mdio_oe};
        rise_cnt <= rise_cnt + 1;
      end
      if (!mdc && mdc_prev) begin
        if (rise_cnt >= rsp_start && rise_cnt < rsp_start + 16)
          mdio_i <= rsp_data[15 - (rise_cnt - rsp_start)];
        else
          mdio_i <= 1'b1;
      end
    end
    mdc_prev <= mdc;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    host_sel = sel;
    @(negedge clk);
    d = host_rdata;
  endtask

  // counts status samples with busy and not-valid high until busy is seen low
  task automatic count_busy(output int nb, output int nn);
    nb = 0; nn = 0;
    host_sel = 3'd5;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (host_rdata[0]) nb++;
      if (host_rdata[2]) nn++;
      if (nb > 0 && !host_rdata[0]) break;
    end
  endtask

  function automatic int half_of(input int code);
    case (code)
      0, 1: return 2;
      2: return 3;
      3: return 4;
      4: return 5;
      5: return 7;
      6: return 10;
      default: return 14;
    endcase
  endfunction

  task automatic exp_frame(input bit rd, input bit nopre, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] d,
                           output logic [63:0] eo, output logic [63:0] eoe, output int n);
    logic [31:0] body, boe;
    body = rd ? {2'b01, 2'b10, phy, rg, 2'b11, 16'hFFFF} : {2'b01, 2'b01, phy, rg, 2'b10, d};
    boe  = rd ? {14'h3FFF, 18'h0} : 32'hFFFF_FFFF;
    if (nopre) begin eo = {32'h0, body}; eoe = {32'h0, boe}; n = 32; end
    else begin eo = {32'hFFFF_FFFF, body}; eoe = {32'hFFFF_FFFF, boe}; n = 64; end
  endtask

  // vector: {rd, nopre, clksel[2:0], phy[4:0], reg[4:0], data[15:0]}
  localparam int NV = 6;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 5'd8,  5'd0,  16'h8000},
    {1'b1, 1'b0, 3'd2, 5'd9,  5'd1,  16'h796D},
    {1'b0, 1'b1, 3'd7, 5'h1E, 5'h11, 16'h0030},
    {1'b1, 1'b1, 3'd5, 5'h1F, 5'h1F, 16'hA5C3},
    {1'b0, 1'b1, 3'd1, 5'd0,  5'd4,  16'h0060},
    {1'b1, 1'b0, 3'd3, 5'd3,  5'h0A, 16'hFFFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] eo, eoe, msk;
    int n, nb, nn, d;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int s = 0; s < 6; s++) begin
      rd_reg(3'(s), r);
      check(r == 0, "R1 register after reset", 64'(r), 64'd0);
    end
    check(!mdc && !mdio_oe, "R1 bus idle after reset", {62'd0, mdc, mdio_oe}, 64'd0);

    // R2: field readback
    wr_reg(3'd2, 32'hFFFF_FFFF);
    rd_reg(3'd2, r);
    check(r == 32'h0000_1F1F, "R2 address fields", 64'(r), 64'h1F1F);
    wr_reg(3'd0, 32'h7FFF_FFFF);
    rd_reg(3'd0, r);
    check(r == 32'h37, "R2 config fields", 64'(r), 64'h37);
    wr_reg(3'd1, 32'hFFFF_FFFE);
    rd_reg(3'd1, r);
    check(r == 32'h2, "R2 command fields, no read launched", 64'(r), 64'h2);
    rd_reg(3'd5, r);
    check(r == 0, "R2 status idle after scan bit", 64'(r), 64'd0);

    // Vector table: R3 R4 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      bit rd, np;
      int sel;
      logic [4:0] ph, rg;
      logic [15:0] dt;
      {rd, np} = VEC[v][30:29];
      sel = int'(VEC[v][28:26]);
      ph = VEC[v][25:21]; rg = VEC[v][20:16]; dt = VEC[v][15:0];
      exp_frame(rd, np, ph, rg, dt, eo, eoe, n);
      msk = (n == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
      d = 2 * half_of(sel);

      wr_reg(3'd0, {27'd0, np, 1'b0, 3'(sel)});
      wr_reg(3'd2, {19'd0, ph, 3'd0, rg});
      if (rd) wr_reg(3'd1, 32'd0);
      rsp_data  = dt;
      rsp_start = rd ? n - 16 : 1000;
      frame_tag++;
      @(negedge clk);
      if (rd) wr_reg(3'd1, 32'd1);
      else    wr_reg(3'd3, {16'hDEAD, dt});
      count_busy(nb, nn);

      check(rise_cnt == n, np ? "R6 frame length without preamble" : "R6 frame length with preamble",
            64'(rise_cnt), 64'(n));
      check(((log_oe ^ eoe) & msk) == 0, rd ? "R4 MDIO release pattern" : "R3 MDIO drive pattern",
            log_oe & msk, eoe);
      check(((log_o ^ eo) & eoe & msk) == 0, rd ? "R4 read frame bits" : "R3 write frame bits",
            log_o & msk, eo);
      check(nb == n * d, "R7 busy width equals bits times divisor", 64'(nb), 64'(n * d));
      check(nn == (rd ? n * d - d / 2 : 0), "R8 not-valid width", 64'(nn), 64'(rd ? n * d - d / 2 : 0));
      if (rd) begin
        rd_reg(3'd4, r);
        check(r == {16'd0, dt}, "R4 read data register", 64'(r), 64'(dt));
      end else begin
        rd_reg(3'd3, r);
        check(r == {16'd0, dt}, "R3 write data readback", 64'(r), 64'(dt));
      end
    end

    // R5: read bit already 1, writing 1 again starts nothing
    wr_reg(3'd1, 32'd1);
    host_sel = 3'd5;
    nb = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (host_rdata[0] || mdc) nb++;
    end
    check(nb == 0, "R5 repeated read bit ignored", 64'(nb), 64'd0);

    // R9: writes and read requests while busy are ignored
    wr_reg(3'd0, 32'h10);
    wr_reg(3'd2, {19'd0, 5'd2, 3'd0, 5'd3});
    wr_reg(3'd1, 32'd0);
    frame_tag++;
    rsp_start = 1000;
    @(negedge clk);
    wr_reg(3'd3, 32'h1234);
    wr_reg(3'd3, 32'hBEEF);
    wr_reg(3'd1, 32'd1);
    count_busy(nb, nn);
    exp_frame(1'b0, 1'b1, 5'd2, 5'd3, 16'h1234, eo, eoe, n);
    check(((log_o ^ eo) & 64'hFFFF_FFFF) == 0 && rise_cnt == 32, "R9 running frame unchanged",
          log_o, eo);
    check(nn == 0, "R9 no read flag raised", 64'(nn), 64'd0);
    rd_reg(3'd3, r);
    check(r == 32'h1234, "R9 write data held", 64'(r), 64'h1234);
    rd_reg(3'd5, r);
    check(r == 0, "R9 idle after ignored requests", 64'(r), 64'd0);

    // R10: abort mid-frame
    wr_reg(3'd0, 32'h7);
    wr_reg(3'd1, 32'd0);
    wr_reg(3'd1, 32'd1);
    repeat (50) @(negedge clk);
    wr_reg(3'd0, 32'h8000_0007);
    check(!mdc && !mdio_oe, "R10 bus released after abort", {62'd0, mdc, mdio_oe}, 64'd0);
    rd_reg(3'd5, r);
    check(r == 0, "R10 flags clear after abort", 64'(r), 64'd0);
    rd_reg(3'd0, r);
    check(r == 32'h7, "R10 abort bit reads 0", 64'(r), 64'h7);

    // R11: MDC stays low while idle
    nb = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mdc) nb++;
    end
    check(nb == 0, "R11 MDC low while idle", 64'(nb), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule